// File: doc/BRIEF.md
# Challenge-Sequenced Device Signature Authenticator

This block turns a single-bit delay-race cell into a multi-bit device signature. When a start pulse arrives, it loads an N-bit starting challenge. It then steps that challenge through a maximal-length LFSR, one step per phase, and applies every challenge phase to the external race cell over a request/valid handshake. Each phase returns one decision bit, which is shifted into an M-bit response register. The first bit collected ends up in the most significant position.

The block runs in one of two modes, chosen at start. In enroll mode, the finished response becomes the stored reference. In verify mode, the finished response is compared with that reference by Hamming distance. The block reports a match when the distance is no greater than a programmable threshold. The threshold is needed because repeated readings of the same device drift by a few bits, while two different devices disagree in about half of the M bits.

Top module: `puf_auth_seq`

## Requirements
- R1: On an accepted start with a nonzero seed, the first challenge presented on `race_chal` equals the seed.
- R2: A zero seed is replaced by the constant 1, so the first challenge presented is 1.
- R3: Each later challenge is the previous one shifted left by one place, with bit 0 filled by a feedback bit. For N = 16, the feedback bit is the XOR of bits 15, 14, 12 and 3 of the previous challenge.
- R4: `race_req` stays high with `race_chal` unchanged until the cycle in which `race_valid` is seen. In the cycle after each capture, `race_req` is low.
- R5: A run collects exactly M bits. The bit from the first phase lands in `response[M-1]`, and the bit from the last phase lands in `response[0]`.
- R6: When an enroll run finishes, the reference takes the new response, `match` reads 0 and `distance` reads 0.
- R7: When a verify run finishes, `distance` equals the number of bit positions in which the response and the reference differ.
- R8: When a verify run finishes, `match` is 1 exactly when `distance` is less than or equal to `threshold` as sampled in the last capture cycle.
- R9: `done` goes high for exactly one cycle, in the cycle right after the last capture. In that same cycle `busy` is low.
- R10: A start pulse that arrives while `busy` is high has no effect on the challenges, the mode or the result of the run in progress.
- R11: A start pulse seen while idle makes `busy` and `race_req` high in the next cycle.
- R12: A synchronous reset clears the response, the phase counter, the reference, `busy`, `done`, `match` and `distance`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run (ignored while busy) |
| mode_enroll | input | 1 | 1 = enroll run, 0 = verify run; sampled with start |
| seed | input | CHAL_W | Starting challenge; sampled with start |
| threshold | input | DIST_W | Largest distance still accepted as a match |
| race_req | output | 1 | Request to the race cell |
| race_chal | output | CHAL_W | Challenge applied to the race cell; bit k steers stage k |
| race_valid | input | 1 | Race cell decision strobe |
| race_bit | input | 1 | Race cell decision |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run finishes |
| match | output | 1 | Verify result, held until the next finish or reset |
| distance | output | DIST_W | Hamming distance of the last verify run |
| response | output | RESP_W | Collected response |

## Verification
A wrong LFSR step or a bad seed substitution shows up on `race_chal` within the first two requests, so the bench logs every challenge and compares the whole list. A shift-order or phase-count fault corrupts `response` and moves the `done` cycle by the end of one run. A stale or corrupted reference is visible only through `distance` on the next verify run. For that reason, the tests follow each enroll and each reset with a verify run whose expected distance is known.

// File: rtl/puf_seq_pkg.sv
package puf_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_GAP  = 2'd2
  } phase_state_t;

  function automatic logic [63:0] bit_at(input int unsigned pos);
    bit_at = 64'd1 << (pos - 1);
  endfunction

  // Feedback tap mask for a maximal-length shift register of width n.
  function automatic logic [63:0] lfsr_taps(input int unsigned n);
    case (n)
      4:  lfsr_taps = bit_at(4)  | bit_at(3);
      5:  lfsr_taps = bit_at(5)  | bit_at(3);
      6:  lfsr_taps = bit_at(6)  | bit_at(5);
      7:  lfsr_taps = bit_at(7)  | bit_at(6);
      8:  lfsr_taps = bit_at(8)  | bit_at(6)  | bit_at(5)  | bit_at(4);
      9:  lfsr_taps = bit_at(9)  | bit_at(5);
      10: lfsr_taps = bit_at(10) | bit_at(7);
      11: lfsr_taps = bit_at(11) | bit_at(9);
      12: lfsr_taps = bit_at(12) | bit_at(6)  | bit_at(4)  | bit_at(1);
      16: lfsr_taps = bit_at(16) | bit_at(15) | bit_at(13) | bit_at(4);
      24: lfsr_taps = bit_at(24) | bit_at(23) | bit_at(22) | bit_at(17);
      32: lfsr_taps = bit_at(32) | bit_at(22) | bit_at(2)  | bit_at(1);
      default: lfsr_taps = bit_at(n) | bit_at(n - 1);
    endcase
  endfunction

  function automatic int unsigned popcount64(input logic [63:0] v);
    int unsigned acc;
    acc = 0;
    for (int i = 0; i < 64; i++) acc += int'(v[i]);
    return acc;
  endfunction

endpackage

// File: rtl/puf_lfsr_mixer.sv
module puf_lfsr_mixer #(
  parameter int unsigned CHAL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CHAL_W-1:0] seed,
  input  logic              step,
  output logic [CHAL_W-1:0] chal
);
  import puf_seq_pkg::*;

  localparam logic [63:0]       TAP_ALL   = lfsr_taps(CHAL_W);
  localparam logic [CHAL_W-1:0] TAPS      = TAP_ALL[CHAL_W-1:0];
  localparam logic [CHAL_W-1:0] ZERO_SUB  = CHAL_W'(1);

  logic [CHAL_W-1:0] chal_q;
  logic [CHAL_W-1:0] chal_next;
  logic [CHAL_W-1:0] seed_safe;
  logic              feedback;

  assign feedback  = ^(chal_q & TAPS);
  assign chal_next = {chal_q[CHAL_W-2:0], feedback};
  assign seed_safe = (seed == '0) ? ZERO_SUB : seed;

  always_ff @(posedge clk) begin
    if (rst)       chal_q <= '0;
    else if (load) chal_q <= seed_safe;
    else if (step) chal_q <= chal_next;
  end

  assign chal = chal_q;
endmodule

// File: rtl/puf_phase_ctrl.sv
module puf_phase_ctrl #(
  parameter int unsigned RESP_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  mode_enroll,
  input  logic                  race_valid,
  output logic                  load,
  output logic                  capture,
  output logic                  last,
  output logic                  race_req,
  output logic                  busy,
  output logic                  run_enroll,
  output logic [$clog2(RESP_W)-1:0] phase_cnt
);
  import puf_seq_pkg::*;

  localparam int unsigned PH_W = $clog2(RESP_W);
  localparam logic [PH_W-1:0] LAST_PHASE = PH_W'(RESP_W - 1);

  phase_state_t      state_q;
  logic [PH_W-1:0]   cnt_q;
  logic              enroll_q;

  assign load     = (state_q == PH_IDLE) && start;
  assign capture  = (state_q == PH_REQ) && race_valid;
  assign last     = capture && (cnt_q == LAST_PHASE);
  assign race_req = (state_q == PH_REQ);
  assign busy     = (state_q != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PH_IDLE;
      cnt_q    <= '0;
      enroll_q <= 1'b0;
    end else begin
      case (state_q)
        PH_IDLE: if (start) begin
          state_q  <= PH_REQ;
          cnt_q    <= '0;
          enroll_q <= mode_enroll;
        end
        PH_REQ: if (race_valid) begin
          if (cnt_q == LAST_PHASE) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
          end else begin
            state_q <= PH_GAP;
            cnt_q   <= cnt_q + 1'b1;
          end
        end
        PH_GAP:  state_q <= PH_REQ;
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  assign run_enroll = enroll_q;
  assign phase_cnt  = cnt_q;
endmodule

// File: rtl/puf_resp_match.sv
module puf_resp_match #(
  parameter int unsigned RESP_W = 32,
  parameter int unsigned DIST_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              last,
  input  logic              race_bit,
  input  logic              run_enroll,
  input  logic [DIST_W-1:0] threshold,
  output logic [RESP_W-1:0] response,
  output logic              done,
  output logic              match,
  output logic [DIST_W-1:0] distance
);
  import puf_seq_pkg::*;

  logic [RESP_W-1:0] resp_q;
  logic [RESP_W-1:0] ref_q;
  logic [RESP_W-1:0] resp_next;
  logic [DIST_W-1:0] dist_next;
  logic              done_q;
  logic              match_q;
  logic [DIST_W-1:0] dist_q;

  assign resp_next = {resp_q[RESP_W-2:0], race_bit};
  assign dist_next = DIST_W'(popcount64(64'(resp_next ^ ref_q)));

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_q  <= '0;
      ref_q   <= '0;
      done_q  <= 1'b0;
      match_q <= 1'b0;
      dist_q  <= '0;
    end else begin
      done_q <= last;
      if (capture) resp_q <= resp_next;
      if (last) begin
        if (run_enroll) begin
          ref_q   <= resp_next;
          match_q <= 1'b0;
          dist_q  <= '0;
        end else begin
          match_q <= (dist_next <= threshold);
          dist_q  <= dist_next;
        end
      end
    end
  end

  assign response = resp_q;
  assign done     = done_q;
  assign match    = match_q;
  assign distance = dist_q;
endmodule

// File: rtl/puf_auth_seq.sv
module puf_auth_seq #(
  parameter int unsigned CHAL_W = 16,
  parameter int unsigned RESP_W = 32,
  parameter int unsigned DIST_W = $clog2(RESP_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_enroll,
  input  logic [CHAL_W-1:0] seed,
  input  logic [DIST_W-1:0] threshold,
  output logic              race_req,
  output logic [CHAL_W-1:0] race_chal,
  input  logic              race_valid,
  input  logic              race_bit,
  output logic              busy,
  output logic              done,
  output logic              match,
  output logic [DIST_W-1:0] distance,
  output logic [RESP_W-1:0] response
);
  localparam int unsigned PH_W = $clog2(RESP_W);

  logic            load_ev;
  logic            capture_ev;
  logic            last_ev;
  logic            run_enroll;
  logic [PH_W-1:0] phase_cnt;

  puf_phase_ctrl #(.RESP_W(RESP_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .mode_enroll(mode_enroll),
    .race_valid(race_valid), .load(load_ev), .capture(capture_ev),
    .last(last_ev), .race_req(race_req), .busy(busy),
    .run_enroll(run_enroll), .phase_cnt(phase_cnt)
  );

  puf_lfsr_mixer #(.CHAL_W(CHAL_W)) u_mix (
    .clk(clk), .rst(rst), .load(load_ev), .seed(seed),
    .step(capture_ev), .chal(race_chal)
  );

  puf_resp_match #(.RESP_W(RESP_W), .DIST_W(DIST_W)) u_cmp (
    .clk(clk), .rst(rst), .capture(capture_ev), .last(last_ev),
    .race_bit(race_bit), .run_enroll(run_enroll), .threshold(threshold),
    .response(response), .done(done), .match(match), .distance(distance)
  );
endmodule

// File: rtl/puf_auth_seq_chk.sv
module puf_auth_seq_chk #(
  parameter int unsigned CHAL_W = 16,
  parameter int unsigned RESP_W = 32,
  parameter int unsigned DIST_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              race_req,
  input logic              race_valid,
  input logic [CHAL_W-1:0] race_chal,
  input logic              done,
  input logic              match,
  input logic [DIST_W-1:0] distance,
  input logic [DIST_W-1:0] threshold,
  input logic              run_enroll,
  input logic              last_ev
);
  // R4
  chal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (race_req && !race_valid) |=> $stable(race_chal));

  // R4
  req_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (race_req && race_valid) |=> !race_req);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    last_ev |=> (done && !busy));

  // R11
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && race_req));

  // R8
  match_rule_chk: assert property (@(posedge clk) disable iff (rst)
    (last_ev && !run_enroll) |=> (match == (distance <= $past(threshold))));

  // R6
  enroll_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (last_ev && run_enroll) |=> (!match && distance == '0));

  // R7
  dist_range_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (int'(distance) <= RESP_W));
endmodule

bind puf_auth_seq puf_auth_seq_chk #(
  .CHAL_W(CHAL_W), .RESP_W(RESP_W), .DIST_W(DIST_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .race_req(race_req),
  .race_valid(race_valid), .race_chal(race_chal), .done(done), .match(match),
  .distance(distance), .threshold(threshold), .run_enroll(run_enroll),
  .last_ev(last_ev)
);

// File: tb/tb_puf_auth_seq.sv
module tb_puf_auth_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int M = 32;
  localparam int DW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          mode_enroll = 1'b0;
  logic [N-1:0]  seed = '0;
  logic [DW-1:0] threshold = '0;
  logic          race_req;
  logic [N-1:0]  race_chal;
  logic          race_valid;
  logic          race_bit;
  logic          busy, done, match;
  logic [DW-1:0] distance;
  logic [M-1:0]  response;

  int checks = 0;
  int errors = 0;

  // behavioural race cell controls
  logic [N-1:0] dev_mask = 16'hB5C3;
  logic [M-1:0] flips = '0;
  int           lat = 1;
  logic [N-1:0] chal_log [M];
  int           phase = 0;
  int           wcnt = 0;
  logic         cvalid = 1'b0;
  logic         cbit = 1'b0;
  int           gap_viol = 0;
  int           hold_viol = 0;
  logic         prev_cap = 1'b0;
  logic         prev_wait = 1'b0;
  logic [N-1:0] prev_chal = '0;

  assign race_valid = cvalid;
  assign race_bit   = cbit;

  always #(CLK_PERIOD/2) clk = ~clk;

  puf_auth_seq #(.CHAL_W(N), .RESP_W(M)) dut (
    .clk(clk), .rst(rst), .start(start), .mode_enroll(mode_enroll),
    .seed(seed), .threshold(threshold), .race_req(race_req),
    .race_chal(race_chal), .race_valid(race_valid), .race_bit(race_bit),
    .busy(busy), .done(done), .match(match), .distance(distance),
    .response(response)
  );

  always @(posedge clk) begin
    if (rst || !busy) begin
      cvalid <= 1'b0; wcnt <= 0; phase <= 0;
    end else if (race_req && !cvalid) begin
      if (wcnt >= lat) begin
        cvalid <= 1'b1;
        cbit   <= (^(race_chal & dev_mask)) ^ flips[M-1-phase];
        chal_log[phase] <= race_chal;
        phase  <= phase + 1;
        wcnt   <= 0;
      end else wcnt <= wcnt + 1;
    end else cvalid <= 1'b0;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_cap && race_req) gap_viol++;
      if (prev_wait && race_req && race_chal != prev_chal) hold_viol++;
    end
    prev_cap  = race_req && race_valid;
    prev_wait = race_req && !race_valid;
    prev_chal = race_chal;
  end

  function automatic logic [N-1:0] step16(input logic [N-1:0] c);
    logic fb;
    fb = c[15] ^ c[14] ^ c[12] ^ c[3];
    return {c[14:0], fb};
  endfunction

  function automatic logic [N-1:0] nth_chal(input logic [N-1:0] s, input int k);
    logic [N-1:0] c;
    c = (s == 0) ? 16'd1 : s;
    for (int i = 0; i < k; i++) c = step16(c);
    return c;
  endfunction

  function automatic logic [M-1:0] model_resp(input logic [N-1:0] s,
      input logic [N-1:0] mask, input logic [M-1:0] fl);
    logic [M-1:0] r;
    logic [N-1:0] c;
    r = '0;
    c = (s == 0) ? 16'd1 : s;
    for (int i = 0; i < M; i++) begin
      r[M-1-i] = (^(c & mask)) ^ fl[M-1-i];
      c = step16(c);
    end
    return r;
  endfunction

  function automatic int ones(input logic [M-1:0] v);
    int n;
    logic [M-1:0] x;
    n = 0; x = v;
    while (x != 0) begin x = x & (x - 1); n++; end
    return n;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [N-1:0] s, input logic enr);
    @(negedge clk);
    seed = s; mode_enroll = enr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
  endtask

  task automatic run(input logic [N-1:0] s, input logic enr);
    pulse_start(s, enr);
    wait_done();
  endtask

  task automatic chal_list_ok(input string req, input logic [N-1:0] s);
    int bad;
    bad = 0;
    for (int i = 0; i < M; i++) if (chal_log[i] !== nth_chal(s, i)) bad++;
    chk(req, bad, 0);
  endtask

  task automatic t_reset_state();
    chk("R12 busy", busy, 0); chk("R12 done", done, 0);
    chk("R12 match", match, 0); chk("R12 distance", distance, 0);
    chk("R12 response", response, 0); chk("R4 req idle", race_req, 0);
  endtask

  task automatic t_enroll_a();
    logic [M-1:0] exp;
    dev_mask = 16'hB5C3; flips = '0; lat = 1;
    exp = model_resp(16'hACE1, dev_mask, '0);
    pulse_start(16'hACE1, 1'b1);
    chk("R11 busy after start", busy, 1);
    chk("R11 req after start", race_req, 1);
    chk("R1 first challenge", race_chal, 16'hACE1);
    wait_done();
    chk("R9 done seen", done, 1);
    chk("R9 busy low at done", busy, 0);
    chk("R5 response MSB-first", response, exp);
    chk("R6 enroll match", match, 0);
    chk("R6 enroll distance", distance, 0);
    chal_list_ok("R3 challenge sequence", 16'hACE1);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
  endtask

  task automatic t_verify_same();
    threshold = 6'd3; flips = '0; lat = 0;
    run(16'hACE1, 1'b0);
    chk("R7 same-device distance", distance, 0);
    chk("R8 same-device match", match, 1);
  endtask

  task automatic t_verify_noisy();
    flips = 32'h8000_0101; threshold = 6'd3; lat = 2;
    run(16'hACE1, 1'b0);
    chk("R7 noisy distance", distance, 3);
    chk("R8 distance equal to threshold", match, 1);
    threshold = 6'd2;
    run(16'hACE1, 1'b0);
    chk("R8 distance above threshold", match, 0);
    chk("R5 noisy response", response, model_resp(16'hACE1, dev_mask, flips));
  endtask

  task automatic t_other_device();
    logic [M-1:0] ra, rb;
    int d;
    ra = model_resp(16'hACE1, 16'hB5C3, '0);
    rb = model_resp(16'hACE1, 16'h6E19, '0);
    d = ones(ra ^ rb);
    dev_mask = 16'h6E19; flips = '0; threshold = 6'd4; lat = 1;
    run(16'hACE1, 1'b0);
    chk("R7 other-device distance", distance, d);
    chk("R8 other-device match", match, (d <= 4));
    dev_mask = 16'hB5C3;
  endtask

  task automatic t_zero_seed();
    flips = '0; lat = 1;
    pulse_start('0, 1'b1);
    chk("R2 zero seed substitute", race_chal, 1);
    wait_done();
    chal_list_ok("R2 sequence from substitute", '0);
    chk("R5 zero-seed response", response, model_resp('0, dev_mask, '0));
  endtask

  task automatic t_start_ignored();
    flips = '0; lat = 1; threshold = 6'd0;
    run(16'h1234, 1'b1);
    pulse_start(16'h1234, 1'b0);
    repeat (20) @(negedge clk);
    seed = 16'h0F0F; mode_enroll = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 still busy", busy, 1);
    wait_done();
    chal_list_ok("R10 challenges unchanged", 16'h1234);
    chk("R10 mode kept verify", match, 1);
    chk("R10 distance", distance, 0);
  endtask

  task automatic t_reset_mid();
    logic [M-1:0] ra;
    ra = model_resp(16'hACE1, dev_mask, '0);
    pulse_start(16'hACE1, 1'b0);
    repeat (12) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R12 busy cleared", busy, 0);
    chk("R12 response cleared", response, 0);
    chk("R12 distance cleared", distance, 0);
    chk("R12 match cleared", match, 0);
    threshold = 6'd3; flips = '0;
    run(16'hACE1, 1'b0);
    chk("R12 reference cleared", distance, ones(ra));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_enroll_a();
    t_verify_same();
    t_verify_noisy();
    t_other_device();
    t_zero_seed();
    t_start_ignored();
    t_reset_mid();
    chk("R4 request gap", gap_viol, 0);
    chk("R4 challenge hold", hold_viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule